// File: doc/BRIEF.md
# Root Port Reset Sequencer

This block orders the teardown and restart of a root-port style link subsystem. A one-cycle request with a hot-reset select bit starts a commanded sequence. The sequencer first asks the system to stop issuing transactions. It then sends a one-cycle bus-master-disable strobe downstream and, if selected, holds a hot-reset pulse for a fixed time. After that it raises a clock-stop request and waits for its acknowledge, asserts the local subsystem reset for a fixed time, and ends with a reinit-done strobe.

The link can also drop while the sequencer is idle, without the sequencer having caused it. In that case the block raises a reset-request interrupt and enters flush mode. In flush mode outstanding master work and pending completion data are discarded, and incoming slave requests receive error completions. Once software has cleared the interrupt and masked further interrupts, recovery joins the commanded sequence at the clock-stop step. Flush mode ends only when the local reset is applied.

Top module: `rp_reset_seq`

## Requirements
- R1: A request accepted in idle asserts `txn_stop_req` from the next cycle. It stays high until a cycle in which `txn_idle` is high, or for at most STOP_TIMEOUT (default 256) cycles.
- R2: If the stop phase ends by timeout, `txn_aborted` is set and stays set. If `txn_idle` is high in the last allowed cycle, this counts as a normal end and the bit is not set. The bit is cleared when the next request is accepted.
- R3: The cycle after the stop phase ends, `bme_disable` is high for exactly one cycle.
- R4: When `req_hot_sel` is 1 at acceptance, `hot_reset` is high for HOT_CYCLES (default 16) cycles, starting the cycle after the bus-master-disable strobe. When it is 0, `hot_reset` stays low.
- R5: `clkstop_req` rises after the hot-reset step, or directly after the strobe when no hot reset was selected. It stays high until a cycle in which `clkstop_ack` is high.
- R6: `local_rst` is high for LRST_CYCLES (default 8) cycles, starting the cycle after the acknowledge. It is followed by a one-cycle `reinit_done` strobe, and the block then returns to idle.
- R7: A falling edge on `link_up` while idle sets `flush_mode` and `err_cpl_en`. It also sets a pending interrupt, which appears on `rst_irq` while `irq_mask` is low.
- R8: A link drop during any sequence phase, including the hot and local reset phases that cause one, raises no interrupt.
- R9: `flush_mode` stays high until the local reset is applied, and is low after the sequence completes.
- R10: In the fault state the block waits until `irq_clear` has cleared the pending interrupt and `irq_mask` is high. It then continues at the clock-stop step, with no stop, bus-master-disable or hot-reset phase.
- R11: A request made while a sequence or fault recovery is in progress is ignored and does not restart the sequence.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle reset request |
| req_hot_sel | input | 1 | Hot-reset select, sampled with the request |
| link_up | input | 1 | Downstream link status |
| txn_idle | input | 1 | System reports no transactions in flight |
| clkstop_ack | input | 1 | Clock-stop acknowledge |
| irq_mask | input | 1 | Masks the interrupt; required high for recovery |
| irq_clear | input | 1 | Clears the pending interrupt |
| txn_stop_req | output | 1 | Asks the system to stop transactions |
| bme_disable | output | 1 | Bus-master-disable strobe |
| hot_reset | output | 1 | Hot-reset pulse toward the downstream device |
| clkstop_req | output | 1 | Clock-stop request |
| local_rst | output | 1 | Local subsystem reset |
| rst_irq | output | 1 | Reset-request interrupt |
| flush_mode | output | 1 | Flush of outstanding master work and completion data |
| err_cpl_en | output | 1 | Answer slave requests with error completions |
| reinit_done | output | 1 | Reinitialization complete strobe |
| txn_aborted | output | 1 | Sticky: stop phase ended by timeout |

## Verification
On every cycle, assertions check the following. The disable strobe is a single cycle. The clock-stop request holds until it is acknowledged, and the local reset starts only after an acknowledge. The stop phase never exceeds its timeout, and the hot pulse ends at its length. An interrupt can only be raised from idle, and flush mode falls only under local reset. Other properties depend on scenarios and are shown only by the bench: the exact lengths and order of the phases for random idle and acknowledge delays, the timeout boundary at 255 and 256 cycles, the skipped steps on fault recovery, and requests being ignored mid-sequence.

// File: rtl/rprs_pkg.sv
package rprs_pkg;

    localparam int DEF_STOP_TIMEOUT = 256;
    localparam int DEF_HOT_CYCLES   = 16;
    localparam int DEF_LRST_CYCLES  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STOP,
        ST_BMD,
        ST_HOT,
        ST_CLK,
        ST_LRST,
        ST_REINIT,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic txn_stop;
        logic bmd;
        logic hot;
        logic clk_req;
        logic lrst;
        logic done;
    } seq_out_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic seq_out_t decode_state(input seq_state_e s);
        seq_out_t o;
        o = '0;
        o.txn_stop = (s == ST_STOP);
        o.bmd      = (s == ST_BMD);
        o.hot      = (s == ST_HOT);
        o.clk_req  = (s == ST_CLK);
        o.lrst     = (s == ST_LRST);
        o.done     = (s == ST_REINIT);
        return o;
    endfunction

endpackage

// File: rtl/rprs_timer.sv
module rprs_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rprs_fault.sv
module rprs_fault (
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    input  logic seq_idle,
    input  logic lrst_active,
    input  logic irq_mask,
    input  logic irq_clear,
    output logic fault_evt,
    output logic recover_ok,
    output logic rst_irq,
    output logic flush_mode,
    output logic err_cpl_en
);
    logic link_q;
    logic irq_pend_q;
    logic flush_q;

    assign fault_evt  = seq_idle && link_q && !link_up;
    assign recover_ok = !irq_pend_q && irq_mask;
    assign rst_irq    = irq_pend_q && !irq_mask;
    assign flush_mode = flush_q;
    assign err_cpl_en = flush_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q     <= 1'b0;
            irq_pend_q <= 1'b0;
            flush_q    <= 1'b0;
        end else begin
            link_q <= link_up;
            if (fault_evt) begin
                irq_pend_q <= 1'b1;
            end else if (irq_clear) begin
                irq_pend_q <= 1'b0;
            end
            if (fault_evt) begin
                flush_q <= 1'b1;
            end else if (lrst_active) begin
                flush_q <= 1'b0;
            end
        end
    end

    // R8: an interrupt is only ever raised from idle
    assert_irq_from_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pend_q) |-> $past(seq_idle));

    // R9: flush mode only falls under local reset
    assert_flush_exit_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(flush_q) |-> $past(lrst_active));

    // R7: a detected drop enters flush mode
    assert_drop_flush_R7: assert property (@(posedge clk) disable iff (rst)
        fault_evt |=> flush_q);
endmodule

// File: rtl/rprs_fsm.sv
module rprs_fsm
    import rprs_pkg::*;
#(
    parameter int STOP_TIMEOUT = DEF_STOP_TIMEOUT,
    parameter int HOT_CYCLES   = DEF_HOT_CYCLES,
    parameter int LRST_CYCLES  = DEF_LRST_CYCLES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     req_hot_sel,
    input  logic     txn_idle,
    input  logic     clkstop_ack,
    input  logic     fault_evt,
    input  logic     recover_ok,
    output seq_out_t outs,
    output logic     seq_idle,
    output logic     txn_aborted
);
    localparam int CNT_W = $clog2(max3(STOP_TIMEOUT, HOT_CYCLES, LRST_CYCLES)) + 1;
    localparam logic [CNT_W-1:0] STOP_LAST = CNT_W'(STOP_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] HOT_LAST  = CNT_W'(HOT_CYCLES - 1);
    localparam logic [CNT_W-1:0] LRST_LAST = CNT_W'(LRST_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic             hot_sel_q;
    logic             aborted_q;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             timed_out;

    rprs_timer #(.W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (state_d != state_q),
        .cnt (cnt)
    );

    assign accept    = (state_q == ST_IDLE) && !fault_evt && req_valid;
    assign timed_out = (state_q == ST_STOP) && !txn_idle && (cnt == STOP_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fault_evt)      state_d = ST_FAULT;
                else if (req_valid) state_d = ST_STOP;
            end
            ST_STOP:   if (txn_idle || cnt == STOP_LAST) state_d = ST_BMD;
            ST_BMD:    state_d = hot_sel_q ? ST_HOT : ST_CLK;
            ST_HOT:    if (cnt == HOT_LAST) state_d = ST_CLK;
            ST_CLK:    if (clkstop_ack) state_d = ST_LRST;
            ST_LRST:   if (cnt == LRST_LAST) state_d = ST_REINIT;
            ST_REINIT: state_d = ST_IDLE;
            ST_FAULT:  if (recover_ok) state_d = ST_CLK;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            hot_sel_q <= 1'b0;
            aborted_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                hot_sel_q <= req_hot_sel;
                aborted_q <= 1'b0;
            end else if (timed_out) begin
                aborted_q <= 1'b1;
            end
        end
    end

    assign outs        = decode_state(state_q);
    assign seq_idle    = (state_q == ST_IDLE);
    assign txn_aborted = aborted_q;

    // R1: stop phase never outlasts its timeout
    assert_stop_bounded_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP) |-> (cnt <= STOP_LAST));

    // R3: disable strobe is a single cycle
    assert_bmd_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        outs.bmd |=> !outs.bmd);

    // R4: hot pulse ends exactly at its length
    assert_hot_len_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.hot) |-> ($past(cnt) == HOT_LAST));

    // R5: clock-stop request holds until acknowledged
    assert_clk_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (outs.clk_req && !clkstop_ack) |=> outs.clk_req);

    // R6: local reset only follows an acknowledged clock stop
    assert_lrst_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.lrst) |-> $past(outs.clk_req && clkstop_ack));

    // R6: done strobe is a single cycle followed by idle
    assert_done_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        outs.done |=> (!outs.done && seq_idle));
endmodule

// File: rtl/rp_reset_seq.sv
module rp_reset_seq
    import rprs_pkg::*;
#(
    parameter int STOP_TIMEOUT = DEF_STOP_TIMEOUT,
    parameter int HOT_CYCLES   = DEF_HOT_CYCLES,
    parameter int LRST_CYCLES  = DEF_LRST_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_hot_sel,
    input  logic link_up,
    input  logic txn_idle,
    input  logic clkstop_ack,
    input  logic irq_mask,
    input  logic irq_clear,
    output logic txn_stop_req,
    output logic bme_disable,
    output logic hot_reset,
    output logic clkstop_req,
    output logic local_rst,
    output logic rst_irq,
    output logic flush_mode,
    output logic err_cpl_en,
    output logic reinit_done,
    output logic txn_aborted
);
    seq_out_t outs;
    logic     seq_idle;
    logic     fault_evt;
    logic     recover_ok;

    rprs_fsm #(
        .STOP_TIMEOUT (STOP_TIMEOUT),
        .HOT_CYCLES   (HOT_CYCLES),
        .LRST_CYCLES  (LRST_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_hot_sel (req_hot_sel),
        .txn_idle    (txn_idle),
        .clkstop_ack (clkstop_ack),
        .fault_evt   (fault_evt),
        .recover_ok  (recover_ok),
        .outs        (outs),
        .seq_idle    (seq_idle),
        .txn_aborted (txn_aborted)
    );

    rprs_fault u_fault (
        .clk         (clk),
        .rst         (rst),
        .link_up     (link_up),
        .seq_idle    (seq_idle),
        .lrst_active (outs.lrst),
        .irq_mask    (irq_mask),
        .irq_clear   (irq_clear),
        .fault_evt   (fault_evt),
        .recover_ok  (recover_ok),
        .rst_irq     (rst_irq),
        .flush_mode  (flush_mode),
        .err_cpl_en  (err_cpl_en)
    );

    assign txn_stop_req = outs.txn_stop;
    assign bme_disable  = outs.bmd;
    assign hot_reset    = outs.hot;
    assign clkstop_req  = outs.clk_req;
    assign local_rst    = outs.lrst;
    assign reinit_done  = outs.done;
endmodule

// File: tb/rp_reset_seq_test.sv
`timescale 1ns/1ps
module rp_reset_seq_test;
    localparam int TMO  = 256;
    localparam int HOTC = 16;
    localparam int LRSC = 8;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_hot_sel, link_up, txn_idle, clkstop_ack, irq_mask, irq_clear;
    logic txn_stop_req, bme_disable, hot_reset, clkstop_req, local_rst;
    logic rst_irq, flush_mode, err_cpl_en, reinit_done, txn_aborted;

    int checks = 0;
    int bad = 0;
    int n_stop, n_bmd, n_hot, n_clk, n_lrst, n_done, n_irq, n_flush_clk;
    int f_stop, f_bmd, f_hot, f_clk, f_lrst, f_done;

    always #2 clk = ~clk;

    rp_reset_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_hot_sel(req_hot_sel),
        .link_up(link_up), .txn_idle(txn_idle), .clkstop_ack(clkstop_ack),
        .irq_mask(irq_mask), .irq_clear(irq_clear),
        .txn_stop_req(txn_stop_req), .bme_disable(bme_disable), .hot_reset(hot_reset),
        .clkstop_req(clkstop_req), .local_rst(local_rst), .rst_irq(rst_irq),
        .flush_mode(flush_mode), .err_cpl_en(err_cpl_en), .reinit_done(reinit_done),
        .txn_aborted(txn_aborted)
    );

    function automatic int exp_stop_len(input int d);
        return (d < TMO) ? d + 1 : TMO;
    endfunction

    function automatic int exp_abort(input int d);
        return (d >= TMO) ? 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives txn_idle and clkstop_ack from delays d and a, models the link
    // going down under hot or local reset, and records phase lengths/starts.
    task automatic observe(input int d, input int a, input bit poke);
        int stop_k, clk_k;
        stop_k = 0; clk_k = 0;
        n_stop = 0; n_bmd = 0; n_hot = 0; n_clk = 0; n_lrst = 0; n_done = 0;
        n_irq = 0; n_flush_clk = 0;
        f_stop = -1; f_bmd = -1; f_hot = -1; f_clk = -1; f_lrst = -1; f_done = -1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (txn_stop_req) begin n_stop++; if (f_stop < 0) f_stop = k; end
            if (bme_disable)  begin n_bmd++;  if (f_bmd < 0)  f_bmd = k;  end
            if (hot_reset)    begin n_hot++;  if (f_hot < 0)  f_hot = k;  end
            if (clkstop_req)  begin n_clk++;  if (f_clk < 0)  f_clk = k;  end
            if (local_rst)    begin n_lrst++; if (f_lrst < 0) f_lrst = k; end
            if (reinit_done)  begin n_done++; if (f_done < 0) f_done = k; end
            if (rst_irq) n_irq++;
            if (clkstop_req && flush_mode) n_flush_clk++;
            txn_idle    = txn_stop_req ? (stop_k >= d) : 1'b0;
            clkstop_ack = clkstop_req ? (clk_k >= a) : 1'b0;
            if (txn_stop_req) stop_k++;
            if (clkstop_req) begin
                if (poke && clk_k == 0) req_valid = 1'b1;
                clk_k++;
            end
            if (hot_reset || local_rst) link_up = 1'b0;
            if (reinit_done) begin
                link_up = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_cmd(input bit hot, input int d, input int a, input bit poke);
        @(negedge clk);
        req_valid   = 1'b1;
        req_hot_sel = hot;
        txn_idle    = 1'b0;
        observe(d, a, poke);
        req_hot_sel = $urandom_range(0, 1);
        check("R1 stop length", n_stop, exp_stop_len(d));
        check("R1 stop first cycle", f_stop, 0);
        check("R2 aborted flag", int'(txn_aborted), exp_abort(d));
        check("R3 strobe count", n_bmd, 1);
        check("R3 strobe position", f_bmd, f_stop + n_stop);
        check("R4 hot length", n_hot, hot ? HOTC : 0);
        if (hot) check("R4 hot position", f_hot, f_bmd + 1);
        check("R5 clkstop length", n_clk, a + 1);
        check("R5 clkstop position", f_clk, f_bmd + 1 + n_hot);
        check("R6 lrst length", n_lrst, LRSC);
        check("R6 lrst position", f_lrst, f_clk + n_clk);
        check("R6 done position", f_done, f_lrst + LRSC);
        check("R6 done count", n_done, 1);
        check("R8 no irq on self-caused drop", n_irq, 0);
        check("R8 no flush on self-caused drop", int'(flush_mode), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (poke) check("R11 mid-sequence request ignored", int'(txn_stop_req), 0);
            else      check("R6 idle after done", int'(txn_stop_req | clkstop_req), 0);
        end
    endtask

    task automatic run_fault(input int a);
        @(negedge clk);
        link_up = 1'b0;
        @(negedge clk);
        check("R7 irq raised", int'(rst_irq), 1);
        check("R7 flush set", int'(flush_mode), 1);
        check("R7 error completions", int'(err_cpl_en), 1);
        check("R10 no stop phase", int'(txn_stop_req), 0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 request ignored in fault", int'(txn_stop_req | clkstop_req), 0);
        end
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        @(negedge clk);
        check("R10 irq cleared", int'(rst_irq), 0);
        check("R10 waits for mask", int'(clkstop_req), 0);
        check("R9 flush held", int'(flush_mode), 1);
        irq_mask = 1'b1;
        observe(0, a, 1'b0);
        irq_mask = 1'b0;
        check("R10 skips stop", n_stop, 0);
        check("R10 skips strobe", n_bmd, 0);
        check("R10 skips hot", n_hot, 0);
        check("R10 clkstop length", n_clk, a + 1);
        check("R9 flush during clkstop", n_flush_clk, n_clk);
        check("R6 lrst length after fault", n_lrst, LRSC);
        check("R9 flush cleared", int'(flush_mode), 0);
        check("R9 err completions cleared", int'(err_cpl_en), 0);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", checks + 1, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h0005EED5);
        rst = 1'b1; req_valid = 1'b0; req_hot_sel = 1'b0; link_up = 1'b1;
        txn_idle = 1'b0; clkstop_ack = 1'b0; irq_mask = 1'b0; irq_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset outputs", int'({txn_stop_req, bme_disable, hot_reset, clkstop_req,
              local_rst, rst_irq, flush_mode, err_cpl_en, reinit_done, txn_aborted}), 0);

        run_cmd(1'b1, 0, 0, 1'b0);
        run_cmd(1'b0, 3, 2, 1'b1);
        run_cmd(1'b1, 255, 1, 1'b0);
        run_cmd(1'b0, 256, 0, 1'b0);
        run_cmd(1'b1, 300, 4, 1'b1);
        run_cmd(1'b0, 2, 1, 1'b0);    // R2 sticky cleared by new request
        for (int i = 0; i < 8; i++) begin
            run_cmd($urandom_range(0, 1), $urandom_range(0, 40),
                    $urandom_range(0, 12), $urandom_range(0, 1));
        end
        run_fault(0);
        run_fault($urandom_range(1, 9));
        run_cmd(1'b1, 5, 3, 1'b0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule